// File: doc/BRIEF.md
# Two-Byte Parallel DAC Load Sequencer

This block writes a 12-bit code into a parallel-input DAC that accepts its data as two bytes over an 8-bit bus. A host raises a one-cycle start together with the code and an optional clear request. The block then drives the DAC's byte bus and three control lines through a fixed sequence:

- an optional clear strobe that forces the DAC output to zero;
- the high byte, with the byte-select line high;
- a falling edge on the select line, which latches the high byte;
- the low byte;
- a chip-enable strobe that moves both input registers into the DAC output register.

Setup time, hold time and strobe widths are parameters counted in clock cycles. The host sees a busy level and a one-cycle done pulse. Start requests that arrive while busy are dropped.

Top module: `dac_word_loader`

## Requirements
- R1: Out of reset and whenever idle, busy_o is 0, dac_clr_n_o is 1, dac_ce_n_o is 1, dac_sel_o is 0 and dac_bus_o is 0.
- R2: At the falling edge of dac_sel_o, dac_bus_o carries the high byte. Bit positions 3..0 of that byte hold code bits 11..8, so bit 11 is in position 3.
- R3: While dac_ce_n_o is low, dac_bus_o carries code bits 7..0 in bus positions 7..0.
- R4: When the clear request was 1 at start, dac_clr_n_o goes low for exactly CLR_LOW_CYC cycles. When the request was 0, dac_clr_n_o stays high for the whole load.
- R5: A load always follows the same order: clear strobe (if requested), then select high, then select low, then chip-enable low. dac_clr_n_o and dac_ce_n_o are never low while dac_sel_o is high.
- R6: dac_sel_o is high with the high byte on the bus for SETUP_CYC cycles before it falls. The bus does not change at that falling edge.
- R7: dac_ce_n_o falls SETUP_CYC + HOLD_CYC cycles after dac_sel_o falls, and it stays low for CE_LOW_CYC cycles.
- R8: done_o is a single-cycle pulse that occurs HOLD_CYC cycles after dac_ce_n_o rises. busy_o is 1 from the cycle after an accepted start through the done cycle.
- R9: A start request while busy_o is 1 is ignored. It does not change the load in progress and does not begin another load.
- R10: The upper four bits of the high byte are always driven 0, even when the code is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle load request, used only when idle |
| code_i | input | CODE_W | Code to load |
| clear_req_i | input | 1 | Issue a clear strobe before the bytes |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a load |
| dac_bus_o | output | BUS_W | Byte bus to the DAC |
| dac_clr_n_o | output | 1 | Clear strobe, active low |
| dac_ce_n_o | output | 1 | Commit strobe, active low |
| dac_sel_o | output | 1 | Byte select: high for the high byte, falling edge latches it |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a load. A second start of this kind must leave both bytes and the strobe timing unchanged. The stimulus pulses start with an unrelated code while busy is high. The scoreboard holds one expected item per accepted load, so any extra or corrupted transaction shows up either as a pop from an empty queue or as a byte mismatch. The all-ones code combined with a clear request exercises the zero-padded upper nibble and the clear-before-select ordering in the same load.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_CLR, ST_HI_SET, ST_HI_HOLD,
      ST_LO_SET, ST_CE, ST_CE_HOLD, ST_DONE
   } ld_state_e;
endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load_i)        cnt_q <= load_val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);

   AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7
endmodule

// File: rtl/dac_byte_fmt.sv
module dac_byte_fmt #(
   parameter int CODE_W = 12,
   parameter int BUS_W  = 8
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic              hi_sel_i,
   output logic [BUS_W-1:0]  byte_o
);
   localparam int HI_BITS = CODE_W - BUS_W;

   logic [BUS_W-1:0] hi_byte;
   logic [BUS_W-1:0] lo_byte;

   generate
      if (HI_BITS < 1 || HI_BITS > BUS_W) begin : g_bad_split
         $error("dac_byte_fmt: CODE_W must exceed BUS_W by 1..BUS_W bits");
      end
      for (genvar b = 0; b < BUS_W; b++) begin : g_hi
         if (b < HI_BITS) begin : g_data
            assign hi_byte[b] = code_i[BUS_W + b];
         end else begin : g_pad
            assign hi_byte[b] = 1'b0;
         end
      end
   endgenerate

   assign lo_byte = code_i[BUS_W-1:0];
   assign byte_o  = hi_sel_i ? hi_byte : lo_byte;

   always_comb begin
      if (hi_sel_i && HI_BITS < BUS_W)
         AST_HI_PAD_ZERO: assert ((byte_o >> HI_BITS) == '0); // R10
   end
endmodule

// File: rtl/dac_word_loader.sv
module dac_word_loader
   import dac_load_pkg::*;
#(
   parameter int CODE_W      = 12,
   parameter int BUS_W       = 8,
   parameter int SETUP_CYC   = 2,
   parameter int HOLD_CYC    = 2,
   parameter int CLR_LOW_CYC = 1,
   parameter int CE_LOW_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              clear_req_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [BUS_W-1:0]  dac_bus_o,
   output logic              dac_clr_n_o,
   output logic              dac_ce_n_o,
   output logic              dac_sel_o
);
   localparam int MAX_AB  = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
   localparam int MAX_CD  = (CLR_LOW_CYC > CE_LOW_CYC) ? CLR_LOW_CYC : CE_LOW_CYC;
   localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

   generate
      if (SETUP_CYC < 1 || HOLD_CYC < 1) begin : g_bad_timing
         $error("dac_word_loader: setup and hold must be at least 1 cycle");
      end
      if (CLR_LOW_CYC < 1 || CE_LOW_CYC < 1) begin : g_bad_strobe
         $error("dac_word_loader: strobe widths must be at least 1 cycle");
      end
   endgenerate

   ld_state_e         state_q, state_d;
   logic [CODE_W-1:0] code_q;
   logic              expired;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic [BUS_W-1:0]  fmt_byte;
   logic              hi_phase;

   function automatic logic [CNT_W-1:0] phase_len_m1(ld_state_e st);
      int len;
      case (st)
         ST_CLR:     len = CLR_LOW_CYC;
         ST_HI_SET:  len = SETUP_CYC;
         ST_HI_HOLD: len = HOLD_CYC;
         ST_LO_SET:  len = SETUP_CYC;
         ST_CE:      len = CE_LOW_CYC;
         ST_CE_HOLD: len = HOLD_CYC;
         default:    len = 1;
      endcase
      return CNT_W'(len - 1);
   endfunction

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:    if (start_i) state_d = clear_req_i ? ST_CLR : ST_HI_SET;
         ST_CLR:     if (expired) state_d = ST_HI_SET;
         ST_HI_SET:  if (expired) state_d = ST_HI_HOLD;
         ST_HI_HOLD: if (expired) state_d = ST_LO_SET;
         ST_LO_SET:  if (expired) state_d = ST_CE;
         ST_CE:      if (expired) state_d = ST_CE_HOLD;
         ST_CE_HOLD: if (expired) state_d = ST_DONE;
         default:    state_d = ST_IDLE;
      endcase
   end

   assign tmr_load = (state_d != state_q);
   assign tmr_val  = phase_len_m1(state_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         code_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) code_q <= code_i;
      end
   end

   dac_phase_timer #(.CNT_W(CNT_W)) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expired_o  (expired)
   );

   assign hi_phase = (state_q == ST_HI_SET) || (state_q == ST_HI_HOLD);

   dac_byte_fmt #(.CODE_W(CODE_W), .BUS_W(BUS_W)) i_fmt (
      .code_i   (code_q),
      .hi_sel_i (hi_phase),
      .byte_o   (fmt_byte)
   );

   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = (state_q == ST_DONE);
   assign dac_clr_n_o = (state_q != ST_CLR);
   assign dac_ce_n_o  = (state_q != ST_CE);
   assign dac_sel_o   = (state_q == ST_HI_SET);
   assign dac_bus_o   = (state_q == ST_IDLE || state_q == ST_CLR) ? '0 : fmt_byte;

   AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (dac_clr_n_o && dac_ce_n_o && !dac_sel_o && dac_bus_o == '0)); // R1
   AST_STROBES_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_clr_n_o || !dac_ce_n_o) |-> !dac_sel_o); // R5
   AST_BUS_STABLE_AT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_sel_o) |-> $stable(dac_bus_o)); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8
   AST_CODE_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(code_q)); // R9
   AST_CE_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_ce_n_o && !$past(dac_ce_n_o)) |-> $stable(dac_bus_o)); // R3
endmodule

// File: tb/test_dac_word_loader.sv
module test_dac_word_loader;
   localparam int CODE_W = 12;
   localparam int BUS_W  = 8;
   localparam int SETUP  = 2;
   localparam int HOLD   = 2;
   localparam int CLRW   = 3;
   localparam int CEW    = 2;

   typedef struct packed {
      logic [7:0] hi;
      logic [7:0] lo;
      logic       clr;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [CODE_W-1:0] code_i = '0;
   logic clear_req_i = 1'b0;
   logic busy_o, done_o, dac_clr_n_o, dac_ce_n_o, dac_sel_o;
   logic [BUS_W-1:0] dac_bus_o;

   always #5 clk = ~clk;

   dac_word_loader #(
      .CODE_W(CODE_W), .BUS_W(BUS_W), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD),
      .CLR_LOW_CYC(CLRW), .CE_LOW_CYC(CEW)
   ) i_dac_word_loader (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_i(code_i),
      .clear_req_i(clear_req_i), .busy_o(busy_o), .done_o(done_o),
      .dac_bus_o(dac_bus_o), .dac_clr_n_o(dac_clr_n_o),
      .dac_ce_n_o(dac_ce_n_o), .dac_sel_o(dac_sel_o)
   );

   exp_t exp_q[$];
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic do_load(input logic [11:0] code, input logic clr, input bit poke);
      exp_t e;
      while (busy_o) @(negedge clk);
      e.hi = {4'b0000, code[11:8]};
      e.lo = code[7:0];
      e.clr = clr;
      exp_q.push_back(e);
      start_i = 1'b1; code_i = code; clear_req_i = clr;
      @(negedge clk);
      start_i = 1'b0; code_i = '0; clear_req_i = 1'b0;
      chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
      if (poke) begin
         for (int k = 0; k < 6; k++) begin
            start_i = 1'b1; code_i = 12'h5E1; clear_req_i = ~clr;
            @(negedge clk);
         end
         start_i = 1'b0; code_i = '0; clear_req_i = 1'b0;
      end
   endtask

   // monitor / scoreboard
   int cyc = 0;
   bit active = 0;
   exp_t cur;
   logic p_clr_n = 1, p_ce_n = 1, p_sel = 0;
   logic [7:0] p_bus = 0;
   int t_clr_fall, t_sel_rise, t_sel_fall, t_ce_fall, t_ce_rise;
   bit saw_clr = 0;
   bit after_done = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (after_done) begin
            after_done = 0;
            chk(!busy_o && dac_clr_n_o && dac_ce_n_o && !dac_sel_o && dac_bus_o == 0,
                "R1 idle levels after done", {busy_o, dac_clr_n_o, dac_ce_n_o, dac_sel_o}, 4'b0110);
         end
         if ((!dac_clr_n_o && p_clr_n) || (dac_sel_o && !p_sel)) begin
            if (!active) begin
               if (exp_q.size() == 0) begin
                  chk(0, "R9 unexpected load started", 1, 0);
               end else begin
                  cur = exp_q.pop_front();
                  active = 1; saw_clr = 0;
               end
            end
         end
         if (!dac_clr_n_o && p_clr_n) begin
            t_clr_fall = cyc;
            saw_clr = 1;
            chk(cur.clr == 1'b1, "R4 clear strobe without request", 1, cur.clr);
         end
         if (dac_clr_n_o && !p_clr_n)
            chk(cyc - t_clr_fall == CLRW, "R4 clear width", cyc - t_clr_fall, CLRW);
         if (dac_sel_o && !p_sel) begin
            t_sel_rise = cyc;
            chk(saw_clr == cur.clr && dac_clr_n_o, "R5 clear before select", saw_clr, cur.clr);
         end
         if (!dac_sel_o && p_sel) begin
            t_sel_fall = cyc;
            chk(cyc - t_sel_rise == SETUP, "R6 select high width", cyc - t_sel_rise, SETUP);
            chk(dac_bus_o == cur.hi, "R2 high byte at latch", dac_bus_o, cur.hi);
            chk(p_bus == cur.hi, "R6 bus before select fall", p_bus, cur.hi);
            chk(dac_bus_o[7:4] == 4'b0, "R10 high nibble zero", dac_bus_o[7:4], 0);
         end
         if (!dac_ce_n_o && p_ce_n) begin
            t_ce_fall = cyc;
            chk(cyc - t_sel_fall == SETUP + HOLD, "R7 chip enable delay", cyc - t_sel_fall, SETUP + HOLD);
            chk(dac_bus_o == cur.lo, "R3 low byte at commit", dac_bus_o, cur.lo);
         end
         if (!dac_ce_n_o)
            chk(dac_bus_o == cur.lo, "R3 low byte during strobe", dac_bus_o, cur.lo);
         if (dac_ce_n_o && !p_ce_n) begin
            t_ce_rise = cyc;
            chk(cyc - t_ce_fall == CEW, "R7 chip enable width", cyc - t_ce_fall, CEW);
         end
         if (done_o) begin
            chk(active && cyc - t_ce_rise == HOLD, "R8 done timing", cyc - t_ce_rise, HOLD);
            chk(busy_o == 1'b1, "R8 busy at done", busy_o, 1);
            if (!cur.clr) chk(!saw_clr, "R4 no clear strobe", saw_clr, 0);
            active = 0;
            after_done = 1;
         end
         p_clr_n = dac_clr_n_o; p_ce_n = dac_ce_n_o; p_sel = dac_sel_o; p_bus = dac_bus_o;
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o && dac_clr_n_o && dac_ce_n_o && !dac_sel_o && dac_bus_o == 0,
          "R1 reset levels", {busy_o, dac_clr_n_o, dac_ce_n_o, dac_sel_o}, 4'b0110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && dac_clr_n_o && dac_ce_n_o && !dac_sel_o, "R1 idle after reset",
          {busy_o, dac_clr_n_o, dac_ce_n_o, dac_sel_o}, 4'b0110);
      do_load(12'hA5C, 1'b0, 1'b0);
      do_load(12'hFFF, 1'b1, 1'b0);   // R10 all-ones with clear
      do_load(12'h000, 1'b1, 1'b1);   // R9 starts while busy
      do_load(12'h3C7, 1'b0, 1'b1);   // R9
      do_load(12'h80F, 1'b1, 1'b0);
      while (busy_o) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0 && !active, "R9 all expected loads seen", exp_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule